// File: doc/BRIEF.md
# Banked Program ROM Address Mapper

This block sits between the instruction fetch logic and a 16K x 8 program ROM. It turns a 13-bit logical fetch address into a 14-bit physical ROM address. The ROM is organised as four 4K banks. Logical addresses in the lower half, 0000h–0FFFh, always reach bank 0, which is the common bank. Logical addresses in the upper half, 1000h–1FFFh, go to one of three switchable banks. A 2-bit bank-select register chooses which one, and the fetch logic writes it through a simple write port.

The block also generates the fixed entry addresses, so the fetch logic never needs to hold them. These are the reset start address, six interrupt entry points, and sixteen short-call entry points. A 2-bit fetch-kind input picks the address source: the program counter or one of the three entry generators. An index input chooses the entry within a group. The result is combinational from these inputs and the current bank-select register. A write to the register changes the mapping only from the following clock cycle.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset, `bank_sel` reads 0, so an upper-half fetch reaches bank 1.
- R2: When `bank_wr_en` is high at a rising clock edge, `bank_sel` takes `bank_wr_data` from that edge on. With `bank_wr_en` low, `bank_sel` keeps its value.
- R3: A fetch presented in the same cycle as a bank write is translated with the old bank value. The new value applies from the next cycle.
- R4: With `fetch_kind` = 00 (program counter) and `pc[12]` = 0, `rom_addr` = {2'b00, `pc[11:0]`}, whatever the bank register holds.
- R5: With `fetch_kind` = 00 and `pc[12]` = 1, `rom_addr` = {bank, `pc[11:0]`}. The bank is 1 when `bank_sel` = 00, 2 when it is 01, and 3 when it is 10.
- R6: The reserved bank-select value 11 maps the upper half to bank 3.
- R7: With `fetch_kind` = 01 (reset entry), `rom_addr` = 0000h, whatever `pc`, `entry_idx` and the bank register hold.
- R8: With `fetch_kind` = 10 (interrupt entry), `rom_addr` = 0002h + 2·`entry_idx` for indices 0 to 5. Any index above 5 gives 000Ch.
- R9: With `fetch_kind` = 11 (short-call entry), `rom_addr` = 000Eh + 8·`entry_idx` for indices 0 to 15. Index 15 gives 0086h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bank register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_wr_en | input | 1 | Write strobe for the bank-select register |
| bank_wr_data | input | 2 | Value to load into the bank-select register |
| fetch_kind | input | 2 | Address source: 00 program counter, 01 reset, 10 interrupt, 11 short call |
| entry_idx | input | 4 | Which interrupt or short-call entry is fetched |
| pc | input | 13 | Logical program counter |
| rom_addr | output | 14 | Physical ROM address |
| bank_sel | output | 2 | Current bank-select register value |

## Verification
The bench builds the block with its default parameters: a 12-bit bank offset, a 2-bit bank number, six interrupt entries and sixteen short-call entries. With these values every bank-select code can be reached, including the reserved code 11, and so can both window edges (0FFFh and 1000h, 1FFFh). The first and last entry of each vector group are also in reach, as is an interrupt index past the end of its group. Short test cases cover the write-versus-fetch ordering and a reset applied in the middle of the run.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {
    FK_PC    = 2'b00,
    FK_RESET = 2'b01,
    FK_IRQ   = 2'b10,
    FK_SCALL = 2'b11
  } fetch_kind_e;
endpackage

// File: rtl/rbm_bank_reg.sv
module rbm_bank_reg #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] sel_q
);
  // The new value is seen by fetches from the next cycle only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_data;
  end
endmodule

// File: rtl/rbm_entry_gen.sv
module rbm_entry_gen #(
  parameter int LA_W         = 13,
  parameter int IDX_W        = 4,
  parameter int N_IRQ        = 6,
  parameter int IRQ_BASE     = 2,
  parameter int IRQ_STRIDE   = 2,
  parameter int SCALL_BASE   = 14,
  parameter int SCALL_STRIDE = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [LA_W-1:0]  irq_addr,
  output logic [LA_W-1:0]  scall_addr
);
  localparam logic [IDX_W-1:0] IRQ_LAST = IDX_W'(N_IRQ - 1);

  logic [IDX_W-1:0] irq_idx;

  // Interrupt indices past the last entry saturate to the last entry
  always_comb begin
    irq_idx    = (idx > IRQ_LAST) ? IRQ_LAST : idx;
    irq_addr   = LA_W'(IRQ_BASE + IRQ_STRIDE * int'(irq_idx));
    scall_addr = LA_W'(SCALL_BASE + SCALL_STRIDE * int'(idx));
  end
endmodule

// File: rtl/rbm_translate.sv
module rbm_translate #(
  parameter int WIN_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic [WIN_W:0]        laddr,
  input  logic [BANK_W-1:0]     sel,
  output logic [BANK_W+WIN_W-1:0] paddr
);
  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  logic [BANK_W-1:0] upper_bank;
  logic [BANK_W-1:0] bank_no;

  // Code k picks bank k+1; the top code saturates on the top bank
  always_comb begin
    upper_bank = (sel == TOP_BANK) ? TOP_BANK : sel + 1'b1;
    bank_no    = laddr[WIN_W] ? upper_bank : '0;
    paddr      = {bank_no, laddr[WIN_W-1:0]};
  end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper #(
  parameter int WIN_W        = 12,
  parameter int BANK_W       = 2,
  parameter int IDX_W        = 4,
  parameter int N_IRQ        = 6,
  parameter int IRQ_BASE     = 2,
  parameter int IRQ_STRIDE   = 2,
  parameter int SCALL_BASE   = 14,
  parameter int SCALL_STRIDE = 8,
  localparam int LA_W        = WIN_W + 1,
  localparam int PA_W        = BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr_en,
  input  logic [BANK_W-1:0] bank_wr_data,
  input  logic [1:0]        fetch_kind,
  input  logic [IDX_W-1:0]  entry_idx,
  input  logic [LA_W-1:0]   pc,
  output logic [PA_W-1:0]   rom_addr,
  output logic [BANK_W-1:0] bank_sel
);
  import rbm_pkg::*;

  logic [LA_W-1:0] irq_addr;
  logic [LA_W-1:0] scall_addr;
  logic [LA_W-1:0] laddr;
  fetch_kind_e     kind;

  rbm_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bank_wr_en),
    .wr_data(bank_wr_data),
    .sel_q  (bank_sel)
  );

  rbm_entry_gen #(
    .LA_W(LA_W), .IDX_W(IDX_W), .N_IRQ(N_IRQ),
    .IRQ_BASE(IRQ_BASE), .IRQ_STRIDE(IRQ_STRIDE),
    .SCALL_BASE(SCALL_BASE), .SCALL_STRIDE(SCALL_STRIDE)
  ) u_entry (
    .idx       (entry_idx),
    .irq_addr  (irq_addr),
    .scall_addr(scall_addr)
  );

  always_comb begin
    kind = fetch_kind_e'(fetch_kind);
    unique case (kind)
      FK_PC:    laddr = pc;
      FK_RESET: laddr = '0;
      FK_IRQ:   laddr = irq_addr;
      FK_SCALL: laddr = scall_addr;
      default:  laddr = '0;
    endcase
  end

  rbm_translate #(.WIN_W(WIN_W), .BANK_W(BANK_W)) u_xlat (
    .laddr(laddr),
    .sel  (bank_sel),
    .paddr(rom_addr)
  );
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
  parameter int WIN_W  = 12,
  parameter int BANK_W = 2,
  parameter int IDX_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bank_wr_en,
  input logic [BANK_W-1:0]       bank_wr_data,
  input logic [1:0]              fetch_kind,
  input logic [IDX_W-1:0]        entry_idx,
  input logic [WIN_W:0]          pc,
  input logic [BANK_W+WIN_W-1:0] rom_addr,
  input logic [BANK_W-1:0]       bank_sel
);
  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en |=> bank_sel == $past(bank_wr_data));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr_en |=> $stable(bank_sel));

  // R4
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_kind == 2'b00 && !pc[WIN_W]) |-> rom_addr == {{BANK_W{1'b0}}, pc[WIN_W-1:0]});

  // R5
  high_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_kind == 2'b00 && pc[WIN_W]) |->
      (rom_addr[BANK_W+WIN_W-1:WIN_W] != '0 && rom_addr[WIN_W-1:0] == pc[WIN_W-1:0]));

  // R7
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kind == 2'b01 |-> rom_addr == '0);

  // R8 R9
  entry_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_kind[1] |-> (rom_addr[BANK_W+WIN_W-1:WIN_W] == '0 && !rom_addr[0]));
endmodule

bind rom_bank_mapper rbm_checker #(.WIN_W(WIN_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_wr_en(bank_wr_en), .bank_wr_data(bank_wr_data),
  .fetch_kind(fetch_kind), .entry_idx(entry_idx), .pc(pc),
  .rom_addr(rom_addr), .bank_sel(bank_sel)
);

// File: tb/rom_bank_mapper_bench.sv
module rom_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_wr_en = 1'b0;
  logic [1:0]  bank_wr_data = '0;
  logic [1:0]  fetch_kind = '0;
  logic [3:0]  entry_idx = '0;
  logic [12:0] pc = '0;
  logic [13:0] rom_addr;
  logic [1:0]  bank_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rom_bank_mapper u_rom_bank_mapper (
    .clk(clk), .rst_n(rst_n), .bank_wr_en(bank_wr_en), .bank_wr_data(bank_wr_data),
    .fetch_kind(fetch_kind), .entry_idx(entry_idx), .pc(pc),
    .rom_addr(rom_addr), .bank_sel(bank_sel)
  );

  // {kind, idx, pc, bank code, expected rom_addr}
  localparam int NV = 14;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 4'd0,  13'h0123, 2'd0, 14'h0123},
    {2'd0, 4'd0,  13'h1ABC, 2'd0, 14'h1ABC},
    {2'd0, 4'd0,  13'h1ABC, 2'd1, 14'h2ABC},
    {2'd0, 4'd0,  13'h1FFF, 2'd2, 14'h3FFF},
    {2'd0, 4'd0,  13'h0FFF, 2'd2, 14'h0FFF},
    {2'd0, 4'd0,  13'h1000, 2'd3, 14'h3000},
    {2'd0, 4'd0,  13'h07FF, 2'd3, 14'h07FF},
    {2'd1, 4'd9,  13'h1555, 2'd2, 14'h0000},
    {2'd2, 4'd0,  13'h1555, 2'd1, 14'h0002},
    {2'd2, 4'd5,  13'h0000, 2'd2, 14'h000C},
    {2'd2, 4'd7,  13'h0000, 2'd0, 14'h000C},
    {2'd3, 4'd0,  13'h1234, 2'd2, 14'h000E},
    {2'd3, 4'd7,  13'h0000, 2'd1, 14'h0046},
    {2'd3, 4'd15, 13'h1FFF, 2'd3, 14'h0086}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string kind_tag(logic [1:0] k);
    case (k)
      2'd0:    return "R4 R5 R6";
      2'd1:    return "R7";
      2'd2:    return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state and an upper-half fetch reaches bank 1
    chk("R1 bank_sel", 32'(bank_sel), 32'h0);
    pc = 13'h1000;
    #1;
    chk("R1 rom_addr", 32'(rom_addr), 32'h1000);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bank_wr_en   = 1'b1;
      bank_wr_data = VEC[i][15:14];
      @(negedge clk);
      bank_wr_en = 1'b0;
      fetch_kind = VEC[i][34:33];
      entry_idx  = VEC[i][32:29];
      pc         = VEC[i][28:16];
      #1;
      chk("R2 bank_sel", 32'(bank_sel), 32'(VEC[i][15:14]));
      chk(kind_tag(VEC[i][34:33]), 32'(rom_addr), 32'(VEC[i][13:0]));
    end

    // R3: same-cycle write uses the old bank, next cycle the new one
    @(negedge clk);
    bank_wr_en = 1'b1; bank_wr_data = 2'd0;
    @(negedge clk);
    fetch_kind = 2'd0; pc = 13'h1234;
    bank_wr_data = 2'd2;
    #1;
    chk("R3 old bank", 32'(rom_addr), 32'h1234);
    @(negedge clk);
    bank_wr_en = 1'b0;
    #1;
    chk("R3 new bank", 32'(rom_addr), 32'h3234);

    // R2: no write holds the register over several cycles
    bank_wr_data = 2'd1;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 hold", 32'(bank_sel), 32'h2);

    // R7: reset entry ignores a high bank and high pc
    fetch_kind = 2'd1; pc = 13'h1FFF; entry_idx = 4'd15;
    #1;
    chk("R7 ignore", 32'(rom_addr), 32'h0);

    // R1: reset mid-run clears the bank register
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    fetch_kind = 2'd0; pc = 13'h1800;
    #1;
    chk("R1 mid-run", 32'(bank_sel), 32'h0);
    chk("R1 mid-run addr", 32'(rom_addr), 32'h1800);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule